// File: doc/BRIEF.md
# Configuration File Section Parser

The block sits between a byte source that streams a stored configuration file and a byte sink that expects only the raw configuration data. It first requires a fixed 13-byte opening sequence. It then walks a chain of tagged sections. Each section is one ASCII type byte, a big-endian length, and that many content bytes. Sections of type `a` to `d` carry a 2-byte length and are skipped without being forwarded. The single section of type `e` carries a 4-byte length, and its content is passed to the sink byte by byte.

The input is a valid/ready byte stream with an end-of-file marker on the final byte. While payload is flowing, the input and output are joined with no buffering, so the sink's ready stalls the source directly. The block reports that the payload section was found, the length it announced, completion of the payload, and a sticky error. After completion, any trailing input is drained and dropped. After an error, all input is drained and nothing is forwarded.

Top module: `bitfile_section_parser`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o, found_o, done_o and err_o are all 0.
- R2: The first 13 accepted bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 in that order. Any mismatching byte sets err_o in the cycle after it is accepted.
- R3: A section type byte outside 0x61..0x65 (ASCII `a`..`e`) sets err_o in the cycle after it is accepted.
- R4: A section of type 0x61..0x64 is followed by a 2-byte big-endian length, high byte first. Its content bytes are consumed and never appear on the output.
- R5: Type 0x65 is followed by a 4-byte big-endian length, most significant byte first. In the cycle after the final length byte is accepted, found_o is 1 and pay_len_o holds that length. Both then stay fixed until reset, and no byte is output before found_o is 1.
- R6: The payload bytes appear on out_data_o in input order. out_last_o is 1 with the final payload byte, and done_o is 1 in the cycle after that byte is transferred.
- R7: A 2-byte length above 255 sets err_o after its low byte. A length of exactly 255 is accepted and skipped.
- R8: During the payload, out_valid_o follows in_valid_i, out_data_o follows in_data_i, and in_ready_o follows out_ready_i, so the source is held whenever the sink is not ready.
- R9: If in_last_i arrives on any accepted byte other than the final payload byte, err_o is set. err_o stays set until reset, done_o stays 0, and out_valid_o stays 0 while err_o is 1.
- R10: A zero-length `a`..`d` section is followed directly by the next type byte. A zero-length `e` section sets found_o and done_o with no output byte and pay_len_o equal to 0.
- R11: Once done_o is 1, in_ready_o is 1 and further input bytes are dropped with out_valid_o held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | File byte |
| in_valid_i | input | 1 | File byte valid |
| in_last_i | input | 1 | Marks the final byte of the file |
| in_ready_o | output | 1 | Block accepts the file byte |
| out_data_o | output | 8 | Payload byte |
| out_valid_o | output | 1 | Payload byte valid |
| out_ready_i | input | 1 | Sink accepts the payload byte |
| out_last_o | output | 1 | Marks the final payload byte |
| pay_len_o | output | LEN_W | Announced payload length |
| found_o | output | 1 | Payload section header parsed |
| done_o | output | 1 | Payload fully delivered |
| err_o | output | 1 | Sticky parse error |

## Verification
A wrong parse position shows up in one of two ways. Either err_o is raised at a byte that should be legal, or a header or skipped byte leaks onto out_data_o. The scoreboard catches a leaked or missing byte at the very transfer where it happens. A length assembled in the wrong byte order, or a down-counter that is off by one, shows on pay_len_o one cycle after the header. It also shows as out_last_o on the wrong byte, or as done_o or err_o appearing one byte early or late. Stalls from the sink are checked on every held cycle, since a lost stall would drop a byte within that same transfer.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef enum logic [2:0] {
    ST_PRE, ST_TYPE, ST_LEN, ST_SKIP, ST_PAY, ST_DONE, ST_ERR
  } bfp_state_e;

  localparam logic [7:0] TYPE_LO   = 8'h61;
  localparam logic [7:0] TYPE_HI   = 8'h65;
  localparam logic [7:0] TYPE_PAY  = 8'h65;
  localparam int         LONG_LEN_BYTES  = 4;
  localparam int         SHORT_LEN_BYTES = 2;

  function automatic logic [7:0] pre_byte(input int unsigned idx);
    case (idx)
      0, 10, 11: pre_byte = 8'h00;
      1:         pre_byte = 8'h09;
      12:        pre_byte = 8'h01;
      default:   pre_byte = idx[0] ? 8'hF0 : 8'h0F;
    endcase
  endfunction
endpackage

// File: rtl/bfp_preamble_match.sv
module bfp_preamble_match #(
  parameter int PRE_LEN = 13,
  localparam int IDX_W = $clog2(PRE_LEN)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [7:0] data_i,
  output logic       hit_o,
  output logic       final_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        idx_q <= '0;
    else if (step_i && !final_o && hit_o) idx_q <= idx_q + 1'b1;
  end

  assign hit_o   = data_i == bfp_pkg::pre_byte(32'(idx_q));
  assign final_o = idx_q == IDX_W'(PRE_LEN - 1);
endmodule

// File: rtl/bfp_len_accum.sv
module bfp_len_accum #(
  parameter int LEN_W = 32,
  localparam int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic [7:0]       data_i,
  output logic [LEN_W-1:0] next_o,
  output logic [CNT_W-1:0] taken_o
);
  logic [LEN_W-1:0] val_q;
  logic [CNT_W-1:0] cnt_q;

  assign next_o  = {val_q[LEN_W-9:0], data_i};
  assign taken_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      val_q <= next_o;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bfp_down_count.sv
module bfp_down_count #(
  parameter int LEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             one_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign one_o = cnt_q == LEN_W'(1);
endmodule

// File: rtl/bitfile_section_parser.sv
module bitfile_section_parser #(
  parameter int LEN_W     = 32,
  parameter int SMALL_MAX = 255,
  parameter int PRE_LEN   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             out_last_o,
  output logic [LEN_W-1:0] pay_len_o,
  output logic             found_o,
  output logic             done_o,
  output logic             err_o
);
  import bfp_pkg::*;

  localparam int CNT_W = 3;

  bfp_state_e       state_q, state_d;
  logic             is_pay_q, is_pay_d;
  logic             found_q, found_set;
  logic [LEN_W-1:0] pay_len_q;
  logic             acc, pre_hit, pre_final, cnt_one;
  logic             len_clr, len_shift, len_final, cnt_load;
  logic [LEN_W-1:0] len_next;
  logic [CNT_W-1:0] len_taken;

  assign acc        = in_valid_i && in_ready_o;
  assign in_ready_o = (state_q == ST_PAY) ? out_ready_i : 1'b1;
  assign out_valid_o = (state_q == ST_PAY) && in_valid_i;
  assign out_data_o  = in_data_i;
  assign out_last_o  = out_valid_o && cnt_one;
  assign found_o     = found_q;
  assign pay_len_o   = pay_len_q;
  assign done_o      = state_q == ST_DONE;
  assign err_o       = state_q == ST_ERR;

  assign len_shift = acc && (state_q == ST_LEN);
  assign len_final = len_taken == CNT_W'((is_pay_q ? LONG_LEN_BYTES : SHORT_LEN_BYTES) - 1);

  bfp_preamble_match #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk_i, .rst_ni,
    .step_i (acc && state_q == ST_PRE),
    .data_i (in_data_i),
    .hit_o  (pre_hit),
    .final_o(pre_final)
  );

  bfp_len_accum #(.LEN_W(LEN_W)) u_len (
    .clk_i, .rst_ni,
    .clr_i  (len_clr),
    .shift_i(len_shift),
    .data_i (in_data_i),
    .next_o (len_next),
    .taken_o(len_taken)
  );

  bfp_down_count #(.LEN_W(LEN_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i    (cnt_load),
    .load_val_i(len_next),
    .dec_i     (acc && (state_q == ST_SKIP || state_q == ST_PAY)),
    .one_o     (cnt_one)
  );

  always_comb begin
    state_d   = state_q;
    is_pay_d  = is_pay_q;
    len_clr   = 1'b0;
    cnt_load  = 1'b0;
    found_set = 1'b0;
    if (acc) begin
      unique case (state_q)
        ST_PRE: begin
          if (!pre_hit)       state_d = ST_ERR;
          else if (pre_final) state_d = ST_TYPE;
        end
        ST_TYPE: begin
          if (in_data_i >= TYPE_LO && in_data_i <= TYPE_HI) begin
            state_d  = ST_LEN;
            is_pay_d = in_data_i == TYPE_PAY;
            len_clr  = 1'b1;
          end else begin
            state_d = ST_ERR;
          end
        end
        ST_LEN: begin
          if (len_final) begin
            if (!is_pay_q && len_next > LEN_W'(SMALL_MAX)) begin
              state_d = ST_ERR;
            end else if (is_pay_q) begin
              found_set = 1'b1;
              cnt_load  = 1'b1;
              state_d   = (len_next == '0) ? ST_DONE : ST_PAY;
            end else begin
              cnt_load = 1'b1;
              state_d  = (len_next == '0) ? ST_TYPE : ST_SKIP;
            end
          end
        end
        ST_SKIP: if (cnt_one) state_d = ST_TYPE;
        ST_PAY:  if (cnt_one) state_d = ST_DONE;
        default: ;
      endcase
      // end of file anywhere but the final payload byte is fatal
      if (in_last_i && state_d != ST_DONE) state_d = ST_ERR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PRE;
      is_pay_q  <= 1'b0;
      found_q   <= 1'b0;
      pay_len_q <= '0;
    end else begin
      state_q  <= state_d;
      is_pay_q <= is_pay_d;
      if (found_set && state_d != ST_ERR) begin
        found_q   <= 1'b1;
        pay_len_q <= len_next;
      end
    end
  end
endmodule

// File: rtl/bfp_checker.sv
module bfp_checker #(
  parameter int LEN_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic             out_last_o,
  input logic [LEN_W-1:0] pay_len_o,
  input logic             found_o,
  input logic             done_o,
  input logic             err_o
);
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R9
  AST_NO_OUT_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !out_valid_o); // R9
  AST_DONE_NOT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R9
  AST_STALL_HOLDS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o); // R8
  AST_FOUND_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |=> (found_o && $stable(pay_len_o))); // R5
  AST_NO_OUT_BEFORE_FOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found_o |-> !out_valid_o); // R5
  AST_LAST_GIVES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> done_o); // R6
  AST_DONE_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (in_ready_o && !out_valid_o)); // R11
endmodule

bind bitfile_section_parser bfp_checker #(.LEN_W(LEN_W)) u_bfp_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_last_o(out_last_o),
  .pay_len_o(pay_len_o), .found_o(found_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/bitfile_section_parser_tb.sv
module bitfile_section_parser_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  in_data = 0;
  logic        in_valid = 0, in_last = 0, out_ready = 1;
  logic        in_ready, out_valid, out_last, found, done, err;
  logic [7:0]  out_data;
  logic [31:0] pay_len;
  logic        stall_en = 0;
  int          cyc = 0, n_chk = 0, n_fail = 0;
  logic [8:0]  exp_q[$];
  bit          finished = 0;

  localparam logic [7:0] PRE [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0,
                                      8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};

  always #5 clk = ~clk;

  bitfile_section_parser u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_last_i(in_last), .in_ready_o(in_ready), .out_data_o(out_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_last_o(out_last),
    .pay_len_o(pay_len), .found_o(found), .done_o(done), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= stall_en ? (cyc % 3 != 0) : 1'b1;
  end

  // monitor / scoreboard
  always begin
    @(negedge clk); #3;
    if (rst_n && out_valid && !out_ready) chk("R8 stall holds source", in_ready, 0);
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk("R5/R9 unexpected output byte", {23'd0, out_last, out_data}, 32'h1FF);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R6 payload byte", {23'd0, out_last, out_data}, {23'd0, e});
      end
    end
  end

  task automatic put(input logic [7:0] b, input logic l);
    @(negedge clk);
    in_data = b; in_valid = 1; in_last = l;
    forever begin
      #3;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk); #1;
    in_valid = 0; in_last = 0;
  endtask

  task automatic settle();
    @(negedge clk); #3;
  endtask

  task automatic do_reset();
    stall_en = 0;
    exp_q.delete();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send_pre();
    for (int i = 0; i < 13; i++) put(PRE[i], 0);
  endtask

  task automatic send_hdr(input logic [7:0] t, input logic [31:0] len, input logic l_end);
    put(t, 0);
    if (t == 8'h65) begin
      put(len[31:24], 0); put(len[23:16], 0); put(len[15:8], 0); put(len[7:0], l_end);
    end else begin
      put(len[15:8], 0); put(len[7:0], l_end);
    end
  endtask

  task automatic send_skip(input int n);
    for (int i = 0; i < n; i++) put(8'(i * 3 + 1), 0);
  endtask

  // n bytes of payload; end-of-file flag on byte index last_at (or none if -1)
  task automatic send_pay(input int n, input int seed, input int last_at, input bit final_ok);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'(seed + i * 7);
      exp_q.push_back({final_ok && (i == n - 1), b});
      put(b, i == last_at);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    settle();
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 found", found, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);

    // full file: a(3), b(0), c(255), d(2), e(5)
    send_pre();
    settle(); chk("R2 good preamble no err", err, 0);
    send_hdr(8'h61, 3, 0); send_skip(3);
    send_hdr(8'h62, 0, 0);
    settle(); chk("R10 zero-length skip section", err, 0);
    send_hdr(8'h63, 255, 0); send_skip(255);
    settle(); chk("R7 length 255 accepted", err, 0);
    send_hdr(8'h64, 2, 0); send_skip(2);
    chk("R4 nothing forwarded from skipped sections", found, 0);
    send_hdr(8'h65, 5, 0);
    settle();
    chk("R5 found after long length", found, 1);
    chk("R5 pay_len", pay_len, 5);
    send_pay(5, 8'h21, 4, 1);
    settle();
    chk("R6 done after payload", done, 1);
    chk("R6 all bytes out", exp_q.size(), 0);
    chk("R6 no err", err, 0);
    put(8'hAA, 0); put(8'h55, 0); put(8'h12, 1);
    settle();
    chk("R11 drain keeps done", done, 1);
    chk("R11 drain in_ready", in_ready, 1);
    chk("R5 found held", found, 1);

    // payload with sink backpressure
    do_reset();
    send_pre();
    send_hdr(8'h65, 32'h0000_0014, 0);
    settle(); chk("R5 pay_len 20", pay_len, 20);
    stall_en = 1;
    send_pay(20, 8'h40, 19, 1);
    settle();
    stall_en = 0;
    chk("R8 done under stall", done, 1);
    chk("R8 all bytes out under stall", exp_q.size(), 0);

    // big-endian order of the long length
    do_reset();
    send_pre();
    send_hdr(8'h65, 32'h0102_0304, 0);
    settle(); chk("R5 big-endian length", pay_len, 32'h0102_0304);

    // preamble mismatch at several positions
    for (int p = 0; p < 13; p += 6) begin
      do_reset();
      for (int i = 0; i < p; i++) put(PRE[i], 0);
      put(PRE[p] ^ 8'h80, 0);
      settle(); chk($sformatf("R2 mismatch at byte %0d", p), err, 1);
      send_hdr(8'h65, 2, 0); put(8'h77, 0); put(8'h78, 1);
      settle();
      chk("R9 err sticky", err, 1);
      chk("R9 no found after err", found, 0);
    end

    // bad type bytes
    do_reset(); send_pre(); put(8'h66, 0);
    settle(); chk("R3 type 0x66", err, 1);
    do_reset(); send_pre(); put(8'h60, 0);
    settle(); chk("R3 type 0x60", err, 1);

    // short length over limit
    do_reset(); send_pre(); send_hdr(8'h61, 256, 0);
    settle(); chk("R7 length 256 rejected", err, 1);

    // end of file inside payload
    do_reset(); send_pre(); send_hdr(8'h65, 4, 0);
    send_pay(2, 8'h90, 1, 0);
    settle();
    chk("R9 early eof err", err, 1);
    chk("R9 early eof done", done, 0);
    put(8'h33, 0); put(8'h34, 0);
    settle(); chk("R9 no output after err", exp_q.size(), 0);

    // end of file in a skipped section
    do_reset(); send_pre(); send_hdr(8'h62, 3, 0); put(8'h01, 0); put(8'h02, 0); put(8'h03, 1);
    settle();
    chk("R9 eof without payload section", err, 1);
    chk("R9 found stays 0", found, 0);

    // zero-length payload section
    do_reset(); send_pre(); send_hdr(8'h65, 0, 1);
    settle();
    chk("R10 zero payload found", found, 1);
    chk("R10 zero payload done", done, 1);
    chk("R10 zero payload len", pay_len, 0);
    chk("R10 zero payload err", err, 0);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule